// File: doc/BRIEF.md
# Banked Vector Load Address Engine

This block fetches one vector of elements from an interleaved, multi-bank memory and deposits them, in element order, into a vector register buffer. It supports three ways of forming element addresses: consecutive 8-byte words, a fixed byte stride taken from a scalar operand, and a per-element byte offset taken from an index vector (gather). A single start pulse captures the base address, the stride, the addressing mode and the requested element count. The block then issues at most one memory request per clock.

The memory model has one busy counter per bank. A bank that has just accepted a request cannot take another for a fixed number of clocks, and the issue stage waits while the next element's bank is occupied. As a result, a stride that keeps landing on the same bank runs at the bank recovery rate, while a stride that rotates through the banks streams at one element per clock. Every request returns after a fixed access latency, and a one-clock completion pulse follows the last write into the buffer.

The memory content is modelled as a pure function of the byte address (the address XOR a salt parameter). This lets the order and the addressing of every element be checked at the buffer outputs.

Top module: `strided_vload_unit`

## Requirements
- R1: In mode 0 (and mode 3, treated the same way), element i is fetched from byte address base + 8*i. The value written to buffer entry i is that address XOR the salt 32'h5A3C0F96.
- R2: In mode 1, element i is fetched from byte address base + i*stride, with the stride given in bytes and the sum wrapping at 32 bits.
- R3: In mode 2, element i is fetched from byte address base + idx_vec[i]. The index vector must stay stable while a load runs.
- R4: The bank of a request is byte-address bits [5:3]. After a bank accepts a request in clock e, no request goes to that bank before clock e+6, and the issue of the next element stalls until its bank is free.
- R5: An element issued in clock e is written into the buffer in clock e+11. A 64-element unit-stride load raises done exactly 76 clocks after the clock edge that samples start.
- R6: A 64-element load whose stride is a multiple of 64 bytes, so that every element hits one bank, raises done exactly 12 + 1 + 6*63 = 391 clocks after start.
- R7: A requested length above 64 is treated as 64. Buffer entries at or beyond the effective length keep their previous contents.
- R8: done is high for exactly one clock, in the clock after the last buffer write. With a length of 0, done rises one clock after start and no entry changes.
- R9: A start pulse that arrives while a load is in progress is ignored. The running load's addresses, timing and results are unaffected, and no extra done follows.
- R10: After reset, done is low and every buffer entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-clock pulse that launches a load when the block is idle |
| mode | input | 2 | Addressing mode: 0 unit, 1 constant stride, 2 indexed, 3 as unit |
| base | input | 32 | Byte base address |
| stride | input | 32 | Byte stride for mode 1 |
| vlen | input | 7 | Requested element count, clamped to 64 |
| idx_vec | input | 64x32 | Per-element byte offsets for mode 2 |
| vreg | output | 64x32 | Vector register buffer contents |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with its default values: 64 buffer entries, 8 banks, a 6-clock bank recovery time and a 12-clock access latency. Because there are more banks than recovery clocks, a stride that rotates through all banks streams with no stall. A 64-byte-multiple stride serializes fully, and a 16-byte stride sits in between, reusing each bank after four requests and so stalling in a repeating pattern. Those three regimes give distinct, hand-computable completion times. The 64-entry depth allows a full-length run, a clamp test and a short partial load that leaves the upper buffer entries untouched.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_RSVD   = 2'd3
  } vld_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vld_state_e;
endpackage

// File: rtl/vlu_agen.sv
module vlu_agen
  import vlu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int MVL = 64,
  parameter int ESZ = 8,
  localparam int IW = $clog2(MVL)
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   clear,
  input  logic                   adv,
  input  vld_mode_e              mode,
  input  logic [AW-1:0]          base,
  input  logic [AW-1:0]          stride,
  input  logic [IW-1:0]          sel,
  input  logic [MVL-1:0][AW-1:0] idx_vec,
  output logic [AW-1:0]          addr
);
  logic [AW-1:0] off_q, off_d, step;

  // running offset replaces a multiplier: one add per issued element
  always_comb begin
    step = (mode == MODE_STRIDE) ? stride : AW'(ESZ);
    off_d = off_q;
    if (clear)    off_d = '0;
    else if (adv) off_d = off_q + step;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) off_q <= '0;
    else if (clear || adv) off_q <= off_d;
  end

  assign addr = (mode == MODE_INDEX) ? (base + idx_vec[sel]) : (base + off_q);
endmodule

// File: rtl/vlu_banks.sv
module vlu_banks #(
  parameter int NB   = 8,
  parameter int BUSY = 6,
  localparam int BKW = $clog2(NB),
  localparam int CW  = $clog2(BUSY) + 1
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic [BKW-1:0] bank_sel,
  input  logic           issue,
  output logic           free
);
  logic [NB-1:0] busy_vec;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] cnt_q, cnt_d;
    always_comb begin
      cnt_d = cnt_q;
      if (issue && (bank_sel == BKW'(b))) cnt_d = CW'(BUSY - 1);
      else if (cnt_q != '0)               cnt_d = cnt_q - 1'b1;
    end
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) cnt_q <= '0;
      else         cnt_q <= cnt_d;
    end
    assign busy_vec[b] = (cnt_q != '0);
  end

  assign free = !busy_vec[bank_sel];

  // R4: a bank just used reports busy on the following clock
  if (BUSY > 1) begin : g_chk
    assert_busy_after_issue_R4: assert property (@(posedge clk) disable iff (!arst_n)
      issue |=> busy_vec[$past(bank_sel)]);
  end
  // R4: no request reaches an occupied bank
  assert_issue_free_bank_R4: assert property (@(posedge clk) disable iff (!arst_n)
    issue |-> !busy_vec[bank_sel]);
endmodule

// File: rtl/vlu_mpipe.sv
module vlu_mpipe #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IW  = 6,
  parameter int LAT = 12,
  parameter logic [DW-1:0] SALT = 32'h5A3C0F96,
  localparam int D = LAT - 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          in_vld,
  input  logic [IW-1:0] in_idx,
  input  logic [AW-1:0] in_addr,
  output logic          out_vld,
  output logic [IW-1:0] out_idx,
  output logic [DW-1:0] out_data,
  output logic          inflight
);
  logic [D-1:0]          vld_q;
  logic [D-1:0][IW-1:0]  idx_q;
  logic [D-1:0][AW-1:0]  addr_q;

  for (genvar s = 0; s < D; s++) begin : g_stage
    logic          v_in;
    logic [IW-1:0] i_in;
    logic [AW-1:0] a_in;
    if (s == 0) begin : g_head
      assign v_in = in_vld;
      assign i_in = in_idx;
      assign a_in = in_addr;
    end else begin : g_body
      assign v_in = vld_q[s-1];
      assign i_in = idx_q[s-1];
      assign a_in = addr_q[s-1];
    end
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) vld_q[s] <= 1'b0;
      else         vld_q[s] <= v_in;
    end
    always_ff @(posedge clk) begin
      if (v_in) begin
        idx_q[s]  <= i_in;
        addr_q[s] <= a_in;
      end
    end
  end

  assign out_vld  = vld_q[D-1];
  assign out_idx  = idx_q[D-1];
  assign out_data = DW'(addr_q[D-1]) ^ SALT;
  assign inflight = |vld_q;
endmodule

// File: rtl/strided_vload_unit.sv
module strided_vload_unit
  import vlu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int MVL  = 64,
  parameter int NB   = 8,
  parameter int BUSY = 6,
  parameter int LAT  = 12,
  parameter int ESZ  = 8,
  parameter logic [DW-1:0] SALT = 32'h5A3C0F96,
  localparam int VLW = $clog2(MVL) + 1,
  localparam int IW  = $clog2(MVL),
  localparam int BKW = $clog2(NB),
  localparam int BSH = $clog2(ESZ)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             mode,
  input  logic [AW-1:0]          base,
  input  logic [AW-1:0]          stride,
  input  logic [VLW-1:0]         vlen,
  input  logic [MVL-1:0][AW-1:0] idx_vec,
  output logic [MVL-1:0][DW-1:0] vreg,
  output logic                   done
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      arst_n <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      arst_n <= rst_s1;
    end
  end

  vld_state_e     state_q, state_d;
  vld_mode_e      mode_q, mode_d;
  logic [AW-1:0]  base_q, base_d, stride_q, stride_d;
  logic [VLW-1:0] vl_q, vl_d, cnt_q, cnt_d, vlen_eff;
  logic           done_d;

  logic           accept, want, issue, finish, bank_free, inflight;
  logic [AW-1:0]  addr;
  logic           out_vld;
  logic [IW-1:0]  out_idx;
  logic [DW-1:0]  out_data;

  assign vlen_eff = (vlen > VLW'(MVL)) ? VLW'(MVL) : vlen;
  assign accept   = (state_q == ST_IDLE) && start;
  assign want     = (state_q == ST_RUN) && (cnt_q < vl_q);
  assign issue    = want && bank_free;
  assign finish   = (state_q == ST_RUN) && (cnt_q == vl_q) && !inflight;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    base_d   = base_q;
    stride_d = stride_q;
    vl_d     = vl_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    if (accept) begin
      state_d  = ST_RUN;
      mode_d   = vld_mode_e'(mode);
      base_d   = base;
      stride_d = stride;
      vl_d     = vlen_eff;
      cnt_d    = '0;
    end else if (finish) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
    end else if (issue) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_UNIT;
      base_q   <= '0;
      stride_q <= '0;
      vl_q     <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      base_q   <= base_d;
      stride_q <= stride_d;
      vl_q     <= vl_d;
      cnt_q    <= cnt_d;
      done     <= done_d;
    end
  end

  vlu_agen #(.AW(AW), .MVL(MVL), .ESZ(ESZ)) u_agen (
    .clk(clk), .arst_n(arst_n), .clear(accept), .adv(issue), .mode(mode_q),
    .base(base_q), .stride(stride_q), .sel(cnt_q[IW-1:0]), .idx_vec(idx_vec),
    .addr(addr)
  );

  vlu_banks #(.NB(NB), .BUSY(BUSY)) u_banks (
    .clk(clk), .arst_n(arst_n), .bank_sel(addr[BSH +: BKW]), .issue(issue),
    .free(bank_free)
  );

  vlu_mpipe #(.AW(AW), .DW(DW), .IW(IW), .LAT(LAT), .SALT(SALT)) u_pipe (
    .clk(clk), .arst_n(arst_n), .in_vld(issue), .in_idx(cnt_q[IW-1:0]),
    .in_addr(addr), .out_vld(out_vld), .out_idx(out_idx), .out_data(out_data),
    .inflight(inflight)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int e = 0; e < MVL; e++) vreg[e] <= '0;
    end else if (out_vld) begin
      vreg[out_idx] <= out_data;
    end
  end

  // R8: completion is a single-clock pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> !done);
  // R7: captured length never exceeds the buffer depth
  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!arst_n)
    vl_q <= VLW'(MVL));
  // R7: returning elements land only below the effective length
  assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!arst_n)
    out_vld |-> (VLW'(out_idx) < vl_q));
  // R9: a start seen mid-run leaves the captured operands alone
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_RUN && start) |=> ($stable(base_q) && $stable(vl_q) && $stable(stride_q)));
  // R5: issue count stays within the captured length
  assert_issue_bound_R5: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= vl_q);
endmodule

// File: tb/strided_vload_unit_tb.sv
`timescale 1ns/1ps
module strided_vload_unit_tb;
  localparam logic [31:0] SALT = 32'h5A3C0F96;
  localparam int NC = 8;
  // mode, base, stride, length, expected clocks from start to done
  localparam int T_MODE [NC] = '{0, 1, 1, 1, 2, 1, 0, 1};
  localparam int T_BASE [NC] = '{136, 0, 1024, 8, 4096, 0, 64, 0};
  localparam int T_STR  [NC] = '{0, 8, 256, 16, 0, 24, 0, 512};
  localparam int T_VL   [NC] = '{64, 64, 64, 20, 33, 17, 100, 5};
  localparam int T_CYC  [NC] = '{76, 76, 391, 40, 45, 29, 76, 37};

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] mode;
  logic [31:0] base, stride;
  logic [6:0] vlen;
  logic [63:0][31:0] idx_vec;
  logic [63:0][31:0] vreg;
  logic done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [31:0] shadow [64];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strided_vload_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .stride(stride), .vlen(vlen), .idx_vec(idx_vec), .vreg(vreg), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] elem_addr(input int m, input logic [31:0] b,
                                            input logic [31:0] s, input int i);
    if (m == 1)      return b + 32'(i) * s;
    else if (m == 2) return b + idx_vec[i];
    else             return b + 32'(i * 8);
  endfunction

  task automatic run_case(input int m, input int b, input int s, input int vl,
                          input int expc, input string rt, input string rd,
                          input bit disturb);
    int t0, n, el, bad, first_i;
    logic [31:0] exp_v [64];
    el = (vl > 64) ? 64 : vl;
    for (int i = 0; i < 64; i++)
      exp_v[i] = (i < el) ? (elem_addr(m, 32'(b), 32'(s), i) ^ SALT) : shadow[i];
    @(negedge clk);
    mode = 2'(m); base = 32'(b); stride = 32'(s); vlen = 7'(vl); start = 1'b1;
    @(negedge clk);
    t0 = cyc;
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      if (disturb && n == 30) begin
        mode = 2'd0; base = 32'h0; vlen = 7'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done == 1'b1, rt, "done seen before watchdog", longint'(done), 1);
    check(cyc - t0 == expc, rt, "clocks from start to done", cyc - t0, expc);
    bad = 0; first_i = -1;
    for (int i = 0; i < 64; i++)
      if (vreg[i] !== exp_v[i]) begin
        bad++;
        if (first_i < 0) first_i = i;
      end
    if (first_i >= 0)
      check(1'b0, rd, $sformatf("buffer entry %0d", first_i), vreg[first_i], exp_v[first_i]);
    else
      check(1'b1, rd, "buffer contents", 0, 0);
    for (int i = 0; i < 64; i++) shadow[i] = exp_v[i];
    @(negedge clk);
    check(done == 1'b0, "R8", "done one clock only", longint'(done), 0);
    if (disturb) begin
      n = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (done) n++;
      end
      check(n == 0, "R9", "no extra done after ignored start", n, 0);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; base = '0; stride = '0; vlen = '0;
    for (int i = 0; i < 64; i++) begin
      idx_vec[i] = 32'((63 - i) * 8);
      shadow[i]  = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    bad = 0;
    for (int i = 0; i < 64; i++) if (vreg[i] !== 32'h0) bad++;
    check(bad == 0, "R10", "nonzero entries in reset", bad, 0);
    check(done == 1'b0, "R10", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R1 unit, R2 stride, R3 gather, R4 stall mix, R5/R6 timing, R7 clamp
    for (int c = 0; c < NC; c++) begin
      string rt, rd;
      rt = (c == 2) ? "R6" : ((c == 3 || c == 5 || c == 7) ? "R4" : "R5");
      rd = (T_MODE[c] == 2) ? "R3" : ((T_MODE[c] == 1) ? "R2" : ((c == 6) ? "R7" : "R1"));
      run_case(T_MODE[c], T_BASE[c], T_STR[c], T_VL[c], T_CYC[c], rt, rd, 1'b0);
    end

    // R7: short load leaves upper entries intact
    run_case(1, 32'h200, 40, 6, 18, "R4", "R7", 1'b0);
    // R1: mode 3 behaves as unit stride
    run_case(3, 32'h80, 99, 10, 22, "R5", "R1", 1'b0);
    // R8: zero length finishes one clock after start, nothing written
    run_case(0, 32'h40, 0, 0, 1, "R8", "R8", 1'b0);
    // R9: start during a running same-bank load is ignored
    run_case(1, 32'h800, 512, 64, 391, "R9", "R9", 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule